// File: doc/BRIEF.md
# Programmable PWM Ramp Sequencer

This block drives three PWM outputs. Each channel's duty level is not held in a fixed compare register. A short program of 16-bit instructions sets that level directly, steps it up or down with timed ramps, or jumps back to the start of the program. All channels share one free-running 8-bit counter that advances on an external tick strobe. Each channel compares its current level against that counter to decide its output.

A host talks to the block over a simple byte-wide write bus. One control register at address 0x30 starts and stops the channels. A byte-wide load port for each channel fills that channel's 64-word instruction store, two byte writes per word. The usual flow is to stop a channel, stream in its program, then set its enable bit. Execution then begins at word 0.

Top module: `pwm_ramp_seq`

## Requirements
- R1: Bits 0, 1 and 2 of the control register (address 0x30) enable channels 0, 1 and 2. A stopped channel drives its output low, and its program counter returns to word 0, so re-enabling runs the program from word 0.
- R2: Channel c loads its program through address 0x38+c. Each word is written high byte first, then low byte, and lands at the next word of the store. A control write with bit c clear resets that channel's load pointer and byte phase to word 0.
- R3: A shared 8-bit counter starts at 0 after reset and advances by one on each clock with `tick` high, wrapping from 0xFF to 0x00.
- R4: A running channel's output is high when counter >= level, except that level 0xFF forces it low. LOAD 0x00 therefore gives 256 high counts in 256, LOAD 0x80 gives 128, and LOAD 0xFF gives 0.
- R5: With LOAD support on, a word with bit 14 set and bits 13:8 clear is LOAD. Its bits 7:0 become the level at the next clock edge, and the program counter advances by one.
- R6: Any other word that is not a branch is a ramp. Bit 7 is the direction (0 up, 1 down) and bits 6:0 are the step count. The level moves by one per step period and saturates at 0x00 and 0xFF. The program counter advances only after the last step. A zero step count simply advances.
- R7: A ramp's step period is STEP_SHORT ticks when bit 8 is 0 and STEP_LONG ticks when bit 8 is 1. It is multiplied by PRESCALE when bit 14 is set.
- R8: A word with bits 15 and 13 both set, or the word 0x0000, sends the program counter to word 0. Non-ramp instructions take one clock each.
- R9: A stopped channel keeps its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | PWM counter and step-timer advance strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| pwm_out | output | 3 | One PWM output per channel |
| level | output | 24 | Current level of each channel, channel c in bits 8c+7:8c |

## Verification
The assertions assume a single-cycle write strobe with a stable address. They also assume the control register is the only way a channel stops, so a write clearing bit c is always followed by a low output and a frozen level. The bench issues every bus write as one isolated strobe. It loads programs only after clearing the channel's enable bit, and every program it loads ends in a branch, so execution never reaches unwritten words. Tick gaps are applied only while ramps run, and never while duty is being counted over 256 cycles.

// File: rtl/pwm_ramp_seq.sv
module pwm_ramp_seq #(
  parameter int NCH = 3,
  parameter int DEPTH = 64,
  parameter int STEP_SHORT = 2,
  parameter int STEP_LONG = 4,
  parameter int PRESCALE = 512,
  parameter bit LOAD_EN = 1'b1,
  parameter logic [7:0] CTRL_ADDR = 8'h30,
  parameter logic [7:0] LOAD_BASE = 8'h38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [NCH-1:0]   pwm_out,
  output logic [NCH*8-1:0] level
);
  localparam int PW = $clog2(DEPTH);
  localparam int TW = $clog2(STEP_LONG * PRESCALE + 1);

  logic [7:0]     cnt;
  logic [NCH-1:0] en;
  wire ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= '0;
    end else begin
      cnt <= cnt + 8'(tick);
      if (ctrl_wr) en <= wr_data[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [15:0]   mem [DEPTH];
    logic [PW-1:0] wp, pc;
    logic          ph, busy, dn;
    logic [7:0]    hold, lvl;
    logic [6:0]    left;
    logic [TW-1:0] tmr, per;

    wire ld_wr = wr_en && (wr_addr == LOAD_BASE + 8'(c));
    wire [15:0] ins = mem[pc];
    wire is_br = (ins == 16'h0000) || (ins[15] && ins[13]);
    wire is_ld = LOAD_EN && ins[14] && (ins[13:8] == 6'd0);
    wire [TW-1:0] iper = ins[14] ? (ins[8] ? TW'(STEP_LONG * PRESCALE) : TW'(STEP_SHORT * PRESCALE))
                                 : (ins[8] ? TW'(STEP_LONG) : TW'(STEP_SHORT));

    always_ff @(posedge clk)
      if (ld_wr && ph) mem[wp] <= {hold, wr_data};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; ph <= 1'b0; hold <= '0;
      end else if (ctrl_wr && !wr_data[c]) begin
        wp <= '0; ph <= 1'b0;
      end else if (ld_wr) begin
        if (!ph) begin
          hold <= wr_data;
          ph   <= 1'b1;
        end else begin
          wp <= wp + 1'b1;
          ph <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc <= '0; busy <= 1'b0; dn <= 1'b0; lvl <= '0;
        left <= '0; tmr <= '0; per <= '0;
      end else if (!en[c]) begin
        pc   <= '0;
        busy <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          if (tmr == per - TW'(1)) begin
            tmr  <= '0;
            lvl  <= dn ? ((lvl == 8'h00) ? lvl : lvl - 1'b1)
                       : ((lvl == 8'hFF) ? lvl : lvl + 1'b1);
            left <= left - 1'b1;
            if (left == 7'd1) begin
              busy <= 1'b0;
              pc   <= pc + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      end else if (is_br) begin
        pc <= '0;
      end else if (is_ld) begin
        lvl <= ins[7:0];
        pc  <= pc + 1'b1;
      end else if (ins[6:0] == 7'd0) begin
        pc <= pc + 1'b1;
      end else begin
        busy <= 1'b1;
        left <= ins[6:0];
        dn   <= ins[7];
        per  <= iper;
        tmr  <= '0;
      end
    end

    assign pwm_out[c]       = en[c] && (lvl != 8'hFF) && (cnt >= lvl);
    assign level[c*8 +: 8]  = lvl;
  end
endmodule

// File: rtl/pwm_ramp_seq_chk.sv
module pwm_ramp_seq_chk #(
  parameter int NCH = 3,
  parameter logic [7:0] CTRL_ADDR = 8'h30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [NCH-1:0]   en,
  input logic [NCH-1:0]   pwm_out,
  input logic [NCH*8-1:0] level
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r1_stop_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_ADDR && !wr_data[c]) |=> !pwm_out[c]);
    a_r4_ff_is_off: assert property (@(posedge clk) disable iff (!rst_n)
      (level[c*8 +: 8] == 8'hFF) |-> !pwm_out[c]);
    a_r4_zero_is_on: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && level[c*8 +: 8] == 8'h00) |-> pwm_out[c]);
    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> $stable(level[c*8 +: 8]));
  end
endmodule

bind pwm_ramp_seq pwm_ramp_seq_chk #(.NCH(NCH), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en(en), .pwm_out(pwm_out), .level(level));

// File: tb/sim_pwm_ramp_seq.sv
module sim_pwm_ramp_seq;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [2:0] pwm_out;
  logic [23:0] level;
  int checks = 0, fails = 0, cyc = 0, tick_mode = 0;

  pwm_ramp_seq u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .level(level));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 tick = (tick_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // behavioural reference model
  int m_cnt, m_en[3], m_mem[3][64], m_wp[3], m_ph[3], m_hold[3];
  int m_pc[3], m_lvl[3], m_busy[3], m_left[3], m_dn[3], m_per[3], m_tmr[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int c = 0; c < 3; c++) begin
        m_en[c] = 0; m_wp[c] = 0; m_ph[c] = 0; m_hold[c] = 0; m_pc[c] = 0;
        m_lvl[c] = 0; m_busy[c] = 0; m_left[c] = 0; m_dn[c] = 0; m_per[c] = 0; m_tmr[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        int w;
        w = m_mem[c][m_pc[c]];
        if (m_en[c] == 0) begin
          m_pc[c] = 0; m_busy[c] = 0;
        end else if (m_busy[c] != 0) begin
          if (tick) begin
            m_tmr[c]++;
            if (m_tmr[c] == m_per[c]) begin
              m_tmr[c] = 0;
              if (m_dn[c] != 0) begin if (m_lvl[c] > 0) m_lvl[c]--; end
              else if (m_lvl[c] < 255) m_lvl[c]++;
              m_left[c]--;
              if (m_left[c] == 0) begin m_busy[c] = 0; m_pc[c] = (m_pc[c] + 1) % 64; end
            end
          end
        end else if (w == 0 || (w & 'hA000) == 'hA000) m_pc[c] = 0;
        else if ((w & 'h7F00) == 'h4000) begin m_lvl[c] = w & 255; m_pc[c] = (m_pc[c] + 1) % 64; end
        else if ((w & 127) == 0) m_pc[c] = (m_pc[c] + 1) % 64;
        else begin
          m_busy[c] = 1; m_left[c] = w & 127; m_dn[c] = (w >> 7) & 1; m_tmr[c] = 0;
          m_per[c] = (((w >> 8) & 1) != 0 ? 4 : 2) * (((w >> 14) & 1) != 0 ? 512 : 1);
        end
      end
      if (wr_en && wr_addr == 8'h30)
        for (int c = 0; c < 3; c++) begin
          m_en[c] = wr_data[c];
          if (!wr_data[c]) begin m_wp[c] = 0; m_ph[c] = 0; end
        end
      for (int c = 0; c < 3; c++)
        if (wr_en && wr_addr == 8'(8'h38 + c)) begin
          if (m_ph[c] == 0) begin m_hold[c] = wr_data; m_ph[c] = 1; end
          else begin
            m_mem[c][m_wp[c]] = m_hold[c] * 256 + wr_data;
            m_wp[c] = (m_wp[c] + 1) % 64; m_ph[c] = 0;
          end
        end
      m_cnt = (m_cnt + (tick ? 1 : 0)) % 256;
    end
  end

  // per-clock comparison against the model (R3, R4, R5, R6, R7, R8)
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < 3; c++) begin
      logic eo;
      eo = (m_en[c] != 0) && (m_lvl[c] != 255) && (m_cnt >= m_lvl[c]);
      checks++;
      if (pwm_out[c] !== eo || level[c*8 +: 8] !== 8'(m_lvl[c])) begin
        fails++;
        $display("FAIL R4/R6 ch%0d cycle %0d: out=%b level=%02h expected out=%b level=%02h",
                 c, cyc, pwm_out[c], level[c*8 +: 8], eo, m_lvl[c]);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2 wr_en = 0;
  endtask

  task automatic put_word(int ch, logic [15:0] w);
    bus_wr(8'(8'h38 + ch), w[15:8]);
    bus_wr(8'(8'h38 + ch), w[7:0]);
  endtask

  task automatic duty(int ch, output int n);
    n = 0;
    repeat (256) begin @(negedge clk); n += int'(pwm_out[ch]); end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, mx, mn, seen_top, back;
    logic [7:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", int'(pwm_out), 0);
    check("R3 reset level", int'(level), 0);
    #2 rst_n = 1;

    // R5/R4: LOAD 0x00 -> always on
    put_word(0, 16'h4000); put_word(0, 16'hA000);
    bus_wr(8'h30, 8'h01);
    repeat (4) @(posedge clk);
    duty(0, n); check("R4 LOAD 00 duty", n, 256);

    // R2: clearing enable restarts the load pointer
    bus_wr(8'h30, 8'h00);
    put_word(0, 16'h4080); put_word(0, 16'hA000);
    bus_wr(8'h30, 8'h01);
    repeat (4) @(posedge clk);
    duty(0, n); check("R4 LOAD 80 duty", n, 128);
    check("R2 reloaded level", int'(level[7:0]), 8'h80);

    bus_wr(8'h30, 8'h00);
    put_word(0, 16'h40FF); put_word(0, 16'hA000);
    bus_wr(8'h30, 8'h01);
    repeat (4) @(posedge clk);
    duty(0, n); check("R4 LOAD FF duty", n, 0);

    // R6 up-ramp saturation at 0xFF
    bus_wr(8'h30, 8'h00);
    put_word(0, 16'h40FE); put_word(0, 16'h0003); put_word(0, 16'hA000);
    bus_wr(8'h30, 8'h01);
    mx = 0; mn = 255;
    repeat (60) begin @(negedge clk); if (level[7:0] > mx) mx = level[7:0]; if (level[7:0] < mn) mn = level[7:0]; end
    check("R6 saturate high max", mx, 255);
    check("R6 saturate high min", mn, 254);

    // R6/R8 up-ramp then branch on channel 1
    bus_wr(8'h30, 8'h00);
    put_word(1, 16'h4010); put_word(1, 16'h0005); put_word(1, 16'hA000);
    bus_wr(8'h30, 8'h02);
    mx = 0; seen_top = 0; back = 0;
    repeat (40) begin
      @(negedge clk);
      if (level[15:8] > mx) mx = level[15:8];
      if (level[15:8] == 8'h15) seen_top = 1;
      if (seen_top != 0 && level[15:8] == 8'h10) back = 1;
    end
    check("R6 ramp peak", mx, 8'h15);
    check("R8 branch reload", back, 1);

    // R6/R7 down saturation, no-op ramp, long and prescaled steps on channel 2
    bus_wr(8'h30, 8'h00);
    put_word(2, 16'h4002); put_word(2, 16'h0085); put_word(2, 16'h0080);
    put_word(2, 16'h0103); put_word(2, 16'h4101); put_word(2, 16'h0000);
    tick_mode = 1;
    bus_wr(8'h30, 8'h04);
    mx = 0; mn = 255;
    repeat (3500) begin @(negedge clk); if (level[23:16] > mx) mx = level[23:16]; if (level[23:16] < mn) mn = level[23:16]; end
    check("R6 saturate low", mn, 0);
    check("R7 prescaled step reached", mx, 4);

    // R9/R1: stop holds the level and silences the output
    bus_wr(8'h30, 8'h00);
    @(negedge clk); held = level[23:16];
    repeat (50) @(negedge clk);
    check("R9 level held", int'(level[23:16]), int'(held));
    check("R1 stopped output", int'(pwm_out), 0);
    tick_mode = 0;
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule